// File: doc/BRIEF.md
# Programmable Interlaced Raster Sync Generator

This block produces the timing strobes for an interlaced raster from a single pixel clock. Two free-running counters track the pixel position within a line and the line within a frame. From that position the block drives three outputs: an active-low horizontal sync, a combined vertical output, and a one-clock pixel alignment strobe. The vertical output is a field-parity level in field mode and an active-low vertical sync pulse in pulse mode. Defaults suit a 27 MHz, 625-line raster with 1728 clocks per line, where half a line is 864 clocks.

An eight-bit control byte and a mode pin are presented in parallel. They are captured only on the last clock of each line, so a pulse that has started always finishes with the settings it began with. Each two-bit field is decoded through a nonlinear table: pulse widths of 1, 4, 16 or 128 clocks, and sync-to-vertical delays of 0, 4, 8 or 16 clocks. In field mode one bit moves the field's rising edge later by half a line. No data passes through the block, so every pin is a plain level, and there is no handshake.

Top module: `raster_sync_gen`

## Requirements
- R1: A synchronous reset sets the pixel count and the line count to 0 and the captured settings to all zeros. While reset is held the outputs read hsync_n=1, vfield=1 and align_stb=0. After reset the pixel count runs from 0 to LINE_CLKS-1 and wraps. The line count advances on each wrap and returns to 0 after FRAME_LINES-1. All outputs are registered: the value seen after a clock edge is computed from the (line, pixel) position held before that edge.
- R2: The horizontal width code is ctrl[1:0]: 00 gives 1 clock, 01 gives 4, 10 gives 16 and 11 gives 128. hsync_n is 0 at pixel positions below that width and 1 elsewhere, on every line.
- R3: The vertical delay code is ctrl[3:2]: 00 gives 0 clocks, 01 gives 4, 10 gives 8 and 11 gives 16. This delay D sets the pixel position of the vertical edges that R5 and R6 describe.
- R4: The alignment code is ctrl[7:6], with a value A from 0 to 3. align_stb is 1 only at pixel position A of each line.
- R5: In field mode (mode_sel=0), vfield carries field parity. It goes to 0 at line 0, pixel D. It goes to 1 at line M=(FRAME_LINES-1)/2, at pixel D when ctrl[4]=0 or at pixel D+HALF_CLKS when ctrl[4]=1. It holds its value between those edges. ctrl[5] is unused in this mode.
- R6: In pulse mode (mode_sel=1), vfield is an active-low pulse. One pulse starts at line 0, pixel D, and another at line M, pixel D+HALF_CLKS. The pulse width is taken from ctrl[5:4] using the table in R2. vfield is 1 everywhere else.
- R7: ctrl and mode_sel are captured only when the pixel count is LINE_CLKS-1. The captured values take effect from pixel 0 of the next line. Changes at any other time have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl | input | 8 | Control byte: [1:0] horizontal width, [3:2] vertical delay, [5:4] vertical width or half-line select, [7:6] alignment |
| mode_sel | input | 1 | 0 = field-parity output, 1 = vertical pulse output |
| hsync_n | output | 1 | Horizontal sync, active low |
| vfield | output | 1 | Field parity (mode 0) or vertical sync, active low (mode 1) |
| align_stb | output | 1 | One-clock pixel alignment strobe |

## Verification
The three outputs depend only on the counter position and the captured settings, so a wrong internal state appears at the ports within one line. A slipped pixel count moves the next hsync_n falling edge and the align_stb pulse off their expected clocks. A wrong line count or a wrong half-line offset misplaces a vfield edge within one field. Settings captured at the wrong moment change a pulse width in the middle of a line. The bench compares every output on every clock, so the first clock that diverges is reported.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  // Captured control byte, MSB first: align, vertical width, delay, horizontal width
  typedef struct packed {
    logic [1:0] align;
    logic [1:0] vwid;
    logic [1:0] dly;
    logic [1:0] hwid;
  } rsg_ctrl_t;

  // Nonlinear width table shared by horizontal and vertical pulses
  function automatic logic [7:0] width_clks(input logic [1:0] code);
    case (code)
      2'b00:   width_clks = 8'd1;
      2'b01:   width_clks = 8'd4;
      2'b10:   width_clks = 8'd16;
      default: width_clks = 8'd128;
    endcase
  endfunction

  // Sync-to-vertical edge delay table
  function automatic logic [4:0] delay_clks(input logic [1:0] code);
    case (code)
      2'b00:   delay_clks = 5'd0;
      2'b01:   delay_clks = 5'd4;
      2'b10:   delay_clks = 5'd8;
      default: delay_clks = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/rsg_timebase.sv
module rsg_timebase #(
  parameter int LINE_CLKS   = 1728,
  parameter int FRAME_LINES = 625,
  localparam int PX_W = $clog2(LINE_CLKS),
  localparam int LN_W = $clog2(FRAME_LINES)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PX_W-1:0] px_o,
  output logic [LN_W-1:0] ln_o,
  output logic            eol_o
);

  localparam logic [PX_W-1:0] PX_LAST = PX_W'(LINE_CLKS - 1);
  localparam logic [LN_W-1:0] LN_LAST = LN_W'(FRAME_LINES - 1);

  logic [PX_W-1:0] px_q;
  logic [LN_W-1:0] ln_q;

  assign eol_o = (px_q == PX_LAST);
  assign px_o  = px_q;
  assign ln_o  = ln_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      px_q <= '0;
      ln_q <= '0;
    end else if (eol_o) begin
      px_q <= '0;
      ln_q <= (ln_q == LN_LAST) ? '0 : ln_q + 1'b1;
    end else begin
      px_q <= px_q + 1'b1;
    end
  end

  // R1: counters stay within their ranges
  p_px_range_r1: assert property (@(posedge clk) disable iff (rst)
    (px_q <= PX_LAST) && (ln_q <= LN_LAST));

  // R1: frame wraps to the origin
  p_frame_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (eol_o && ln_q == LN_LAST) |=> (px_q == '0 && ln_q == '0));

endmodule

// File: rtl/rsg_cfg_latch.sv
module rsg_cfg_latch
  import rsg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load_i,
  input  logic [7:0] ctrl_i,
  input  logic      mode_i,
  output rsg_ctrl_t cfg_o,
  output logic      mode_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o  <= '0;
      mode_o <= 1'b0;
    end else if (load_i) begin
      cfg_o  <= rsg_ctrl_t'(ctrl_i);
      mode_o <= mode_i;
    end
  end

  // R7: settings cannot move except at the line boundary
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(cfg_o) && $stable(mode_o)));

endmodule

// File: rtl/rsg_pulse_gen.sv
module rsg_pulse_gen
  import rsg_pkg::*;
#(
  parameter int LINE_CLKS   = 1728,
  parameter int FRAME_LINES = 625,
  parameter int HALF_CLKS   = 864,
  localparam int PX_W = $clog2(LINE_CLKS),
  localparam int LN_W = $clog2(FRAME_LINES),
  localparam int PW   = PX_W + 2,
  localparam int MID  = (FRAME_LINES - 1) / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PX_W-1:0] px_i,
  input  logic [LN_W-1:0] ln_i,
  input  rsg_ctrl_t       cfg_i,
  input  logic            mode_i,
  output logic            hsync_n_o,
  output logic            vfield_o,
  output logic            align_stb_o
);

  localparam logic [LN_W-1:0] LN_MID  = LN_W'(MID);
  localparam logic [PW-1:0]   HALF_PW = PW'(HALF_CLKS);

  logic [PW-1:0] px_w, hw, vw, dl, rise_px, vs_start;
  logic          at_top, at_mid, hs_act, field_d, vs_act, vfield_d, align_d;

  always_comb begin
    px_w    = PW'(px_i);
    hw      = PW'(width_clks(cfg_i.hwid));
    vw      = PW'(width_clks(cfg_i.vwid));
    dl      = PW'(delay_clks(cfg_i.dly));
    at_top  = (ln_i == '0);
    at_mid  = (ln_i == LN_MID);
    rise_px = cfg_i.vwid[0] ? dl + HALF_PW : dl;

    hs_act  = (px_w < hw);

    // Field parity: high from the mid-frame edge until the top-of-frame edge
    field_d = (at_top && px_w < dl) || (ln_i > LN_MID) ||
              (at_mid && px_w >= rise_px);

    vs_start = at_mid ? dl + HALF_PW : dl;
    vs_act   = (at_top || at_mid) && (px_w >= vs_start) &&
               (px_w < vs_start + vw);

    vfield_d = mode_i ? ~vs_act : field_d;
    align_d  = (px_w == PW'(cfg_i.align));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n_o   <= 1'b1;
      vfield_o    <= 1'b1;
      align_stb_o <= 1'b0;
    end else begin
      hsync_n_o   <= ~hs_act;
      vfield_o    <= vfield_d;
      align_stb_o <= align_d;
    end
  end

  // R2: the horizontal pulse always begins at the line origin
  p_hs_start_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n_o) |-> (px_i == PX_W'(1)));

  // R4: the strobe lands one clock after its coded pixel position
  p_align_pos_r4: assert property (@(posedge clk) disable iff (rst)
    align_stb_o |-> (PW'(px_i) == PW'(cfg_i.align) + PW'(1)));

  // R6: vertical pulses appear only on the top and middle lines
  p_vs_lines_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_i && px_i != '0 && !vfield_o) |-> (ln_i == '0 || ln_i == LN_MID));

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import rsg_pkg::*;
#(
  parameter int LINE_CLKS   = 1728,
  parameter int FRAME_LINES = 625,
  parameter int HALF_CLKS   = 864
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] ctrl,
  input  logic       mode_sel,
  output logic       hsync_n,
  output logic       vfield,
  output logic       align_stb
);

  localparam int PX_W = $clog2(LINE_CLKS);
  localparam int LN_W = $clog2(FRAME_LINES);

  logic [PX_W-1:0] px;
  logic [LN_W-1:0] ln;
  logic            eol;
  rsg_ctrl_t       cfg;
  logic            mode_q;

  rsg_timebase #(
    .LINE_CLKS  (LINE_CLKS),
    .FRAME_LINES(FRAME_LINES)
  ) u_timebase (
    .clk  (clk),
    .rst  (rst),
    .px_o (px),
    .ln_o (ln),
    .eol_o(eol)
  );

  rsg_cfg_latch u_cfg (
    .clk   (clk),
    .rst   (rst),
    .load_i(eol),
    .ctrl_i(ctrl),
    .mode_i(mode_sel),
    .cfg_o (cfg),
    .mode_o(mode_q)
  );

  rsg_pulse_gen #(
    .LINE_CLKS  (LINE_CLKS),
    .FRAME_LINES(FRAME_LINES),
    .HALF_CLKS  (HALF_CLKS)
  ) u_pulse (
    .clk        (clk),
    .rst        (rst),
    .px_i       (px),
    .ln_i       (ln),
    .cfg_i      (cfg),
    .mode_i     (mode_q),
    .hsync_n_o  (hsync_n),
    .vfield_o   (vfield),
    .align_stb_o(align_stb)
  );

endmodule

// File: tb/raster_sync_gen_test.sv
module raster_sync_gen_test;

  localparam int LINE  = 300;
  localparam int FRAME = 7;
  localparam int HALF  = 150;
  localparam int MID   = (FRAME - 1) / 2;

  typedef struct packed {
    logic       hs;
    logic       vf;
    logic       al;
    logic       in_rst;
    logic       md;
    logic       glitch;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] ctrl = 8'h00;
  logic       mode_sel = 1'b0;
  logic       hsync_n, vfield, align_stb;

  int checks = 0;
  int fails  = 0;
  bit glitch_flag = 1'b0;

  exp_t exp_q[$];

  // Bench-side position and captured settings
  int mpx = 0, mln = 0, mctrl = 0, mmode = 0;

  always #2 clk = ~clk;

  raster_sync_gen #(
    .LINE_CLKS  (LINE),
    .FRAME_LINES(FRAME),
    .HALF_CLKS  (HALF)
  ) uut (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .mode_sel (mode_sel),
    .hsync_n  (hsync_n),
    .vfield   (vfield),
    .align_stb(align_stb)
  );

  function automatic int wtab(input int c);
    case (c)
      0: return 1;
      1: return 4;
      2: return 16;
      default: return 128;
    endcase
  endfunction

  function automatic int dtab(input int c);
    case (c)
      0: return 0;
      1: return 4;
      2: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic exp_t predict(input int px, input int ln, input int c, input int m);
    exp_t e;
    int hw, vw, d, a, rise, st;
    bit fld, vs;
    hw = wtab(c & 3);
    d  = dtab((c >> 2) & 3);
    vw = wtab((c >> 4) & 3);
    a  = (c >> 6) & 3;
    rise = ((c >> 4) & 1) != 0 ? d + HALF : d;
    fld  = (ln == 0 && px < d) || (ln > MID) || (ln == MID && px >= rise);
    st   = (ln == MID) ? d + HALF : d;
    vs   = (ln == 0 || ln == MID) && px >= st && px < st + vw;
    e.hs = !(px < hw);
    e.vf = (m != 0) ? !vs : fld;
    e.al = (px == a);
    e.in_rst = 1'b0;
    e.md = (m != 0);
    e.glitch = 1'b0;
    return e;
  endfunction

  // Driver-side model: one expected item per clock edge
  always @(posedge clk) begin
    exp_t e;
    if (rst) begin
      e = '{hs: 1'b1, vf: 1'b1, al: 1'b0, in_rst: 1'b1, md: 1'b0, glitch: 1'b0};
      mpx = 0; mln = 0; mctrl = 0; mmode = 0;
    end else begin
      e = predict(mpx, mln, mctrl, mmode);
      e.glitch = glitch_flag;
      if (mpx == LINE - 1) begin
        mctrl = int'(ctrl);
        mmode = int'(mode_sel);
        mpx = 0;
        mln = (mln == FRAME - 1) ? 0 : mln + 1;
      end else begin
        mpx = mpx + 1;
      end
    end
    exp_q.push_back(e);
  end

  task automatic cmp(input logic act, input logic expv, input string tag);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, expv, $time);
    end
  endtask

  // Monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      string g;
      e = exp_q.pop_front();
      g = e.glitch ? " R7" : "";
      if (e.in_rst) begin
        cmp(hsync_n,   e.hs, "R1 reset hsync_n");
        cmp(vfield,    e.vf, "R1 reset vfield");
        cmp(align_stb, e.al, "R1 reset align_stb");
      end else begin
        cmp(hsync_n, e.hs, {"R1 R2 hsync_n", g});
        cmp(vfield,  e.vf, e.md ? {"R3 R6 vfield pulse", g} : {"R3 R5 vfield field", g});
        cmp(align_stb, e.al, {"R4 align_stb", g});
      end
    end
  end

  task automatic set_cfg(input logic [7:0] c, input logic m);
    @(negedge clk);
    ctrl = c;
    mode_sel = m;
  endtask

  task automatic run_lines(input int n);
    repeat (n * LINE) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R5 field mode, delay 4, no half-line, align 2, width 1
    set_cfg(8'h84, 1'b0);
    run_lines(2 * FRAME);
    // R5 field mode with half-line rise, delay 16, width 4, align 1
    set_cfg(8'h5D, 1'b0);
    run_lines(2 * FRAME);
    // R6 pulse mode, width 16 both, delay 8, align 3
    set_cfg(8'hEA, 1'b1);
    run_lines(FRAME + 1);
    // R2 R6 widest pulses, delay 0, align 0
    set_cfg(8'h33, 1'b1);
    run_lines(FRAME + 1);
    // R6 single-clock vertical pulse, delay 16
    set_cfg(8'h0C, 1'b1);
    run_lines(FRAME + 1);
    // R7 mid-line glitch that never reaches a line end
    while (mpx != 20) @(negedge clk);
    glitch_flag = 1'b1;
    ctrl = 8'hFF;
    mode_sel = 1'b0;
    repeat (100) @(negedge clk);
    ctrl = 8'h0C;
    mode_sel = 1'b1;
    run_lines(2);
    glitch_flag = 1'b0;
    // R1 reset in mid-run, then restart
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    set_cfg(8'h01, 1'b0);
    run_lines(FRAME + 2);
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule